// File: doc/BRIEF.md
# Bus Microcycle Sequencer with Whole-Unit Wait States

This block paces an 8-bit processor core against a slower external asynchronous memory bus. It steps through a repeating four-phase microcycle and publishes the current phase as a 3-bit code. It also provides a one-hot strobe per code, a cycle-complete pulse for the core and a capture strobe for read data. A registered two-phase bus clock pair is derived from the phase.

A normal cycle runs address computation (code 6), then bus drive (code 7), then capture and release (code 5), then execute and decode (code 4). The bus Ready input is sampled only in the two capture phases, code 5 and code 1. When Ready is low there, the cycle is stretched by one complete four-phase wait unit, with codes 0, 2, 3 and 1 in that order. The unit repeats for as long as Ready stays low at code 1. Because every extension is a whole unit that keeps the high/low pattern of the bus clocks, both bus clocks stay continuous and symmetric however many wait states are taken.

Top module: `mcyc_seq`

## Requirements
- R1: While reset is asserted the code is 6, the phase-1 clock is 0, the phase-2 clock is 1 and the done pulse is 0.
- R2: With Ready high, the code repeats the sequence 6, 7, 5, 4, and after code 4 the next code is always 6.
- R3: At code 5 with Ready low, the next code is 0, followed by 2, 3 and then 1.
- R4: At code 1, Ready high leads to code 4 next, and Ready low leads to code 0 next, which repeats the wait unit.
- R5: A memory cycle, counted from code 6 to code 4 inclusive, lasts 4 + 4·W clock cycles, where W is the number of low Ready samples taken at codes 5 and 1 during it.
- R6: The phase-1 clock is a register that goes high one clock after codes 5, 4, 1 or 0 and low one clock after codes 6, 7, 2 or 3. The phase-2 clock is always its complement.
- R7: After the first transition that follows reset, every high run and every low run of both bus clocks lasts exactly 2 clock cycles, for any pattern of wait states.
- R8: The strobe vector is one-hot, and bit k is high exactly when the code equals k.
- R9: The done pulse is high only at code 4, that is, in the final phase of a cycle that is not being extended.
- R10: The capture strobe is high exactly when the code is 5 or 1 and Ready is high.
- R11: Ready has no effect on the sequence at codes 6, 7, 4, 0, 2 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst | input | 1 | Asynchronous reset, active high |
| ready_i | input | 1 | Bus Ready; low in a capture phase requests a wait unit |
| code_o | output | 3 | Current microcycle code |
| stb_o | output | 8 | One-hot strobe, bit index equals code |
| done_o | output | 1 | Cycle-complete pulse for the core |
| capture_o | output | 1 | Read-data capture and strobe release |
| ph1_o | output | 1 | Registered phase-1 bus clock |
| ph2_o | output | 1 | Registered phase-2 bus clock |

## Verification
The sweep runs memory cycles with each wait count from zero to six. These cycles separate an off-by-one in the wait exit from a correct exit, and check the 4 + 4·W length together with the symmetry of the bus clocks at every stretch length. In the same cycles Ready is driven with pseudo-random junk in every non-sampling phase, so any code that wrongly reacts to Ready there is exposed. A long pseudo-random Ready run and a strictly alternating Ready run then drive the sampling phases into mixed entries and exits, which exercises the repeat-versus-leave decision at code 1 against the same arithmetic model.

// File: rtl/mcyc_pkg.sv
package mcyc_pkg;
   localparam int CODE_W = 3;
   localparam int NUM_CODES = 1 << CODE_W;

   typedef enum logic [CODE_W-1:0] {
      WT_IDLE  = 3'd0,
      WT_CAPT  = 3'd1,
      WT_ADDR  = 3'd2,
      WT_DRIVE = 3'd3,
      PH_EXEC  = 3'd4,
      PH_CAPT  = 3'd5,
      PH_ADDR  = 3'd6,
      PH_DRIVE = 3'd7
   } mc_code_e;
endpackage

// File: rtl/mcyc_step.sv
module mcyc_step
   import mcyc_pkg::*;
#(
   parameter int W = CODE_W
)(
   input  logic         clk,
   input  logic         rst,
   input  logic         ready_i,
   output logic [W-1:0] code_o
);
   generate
      if (W != CODE_W) begin : g_bad_w
         $error("mcyc_step: code width must match package");
      end
   endgenerate

   mc_code_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         PH_ADDR:  state_d = PH_DRIVE;
         PH_DRIVE: state_d = PH_CAPT;
         PH_CAPT:  state_d = ready_i ? PH_EXEC : WT_IDLE;
         PH_EXEC:  state_d = PH_ADDR;
         WT_IDLE:  state_d = WT_ADDR;
         WT_ADDR:  state_d = WT_DRIVE;
         WT_DRIVE: state_d = WT_CAPT;
         WT_CAPT:  state_d = ready_i ? PH_EXEC : WT_IDLE;
         default:  state_d = PH_ADDR;
      endcase
   end

   always_ff @(posedge clk or posedge rst) begin
      if (rst) state_q <= PH_ADDR;
      else     state_q <= state_d;
   end

   assign code_o = state_q;

   p_enter_wait_r3: assert property (@(posedge clk) disable iff (rst)
      (code_o == PH_CAPT && !ready_i) |=> (code_o == WT_IDLE));
   p_wait_order_r3: assert property (@(posedge clk) disable iff (rst)
      (code_o == WT_ADDR) |=> (code_o == WT_DRIVE));
   p_leave_wait_r4: assert property (@(posedge clk) disable iff (rst)
      (code_o == WT_CAPT && ready_i) |=> (code_o == PH_EXEC));
   p_repeat_wait_r4: assert property (@(posedge clk) disable iff (rst)
      (code_o == WT_CAPT && !ready_i) |=> (code_o == WT_IDLE));
   p_wrap_r2: assert property (@(posedge clk) disable iff (rst)
      (code_o == PH_EXEC) |=> (code_o == PH_ADDR));
   p_ignore_r11: assert property (@(posedge clk) disable iff (rst)
      (code_o == PH_DRIVE) |=> (code_o == PH_CAPT));
endmodule

// File: rtl/mcyc_strobe.sv
module mcyc_strobe
   import mcyc_pkg::*;
#(
   parameter int W = CODE_W,
   localparam int N = 1 << W
)(
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] code_i,
   output logic [N-1:0] stb_o
);
   generate
      for (genvar g = 0; g < N; g++) begin : g_stb
         assign stb_o[g] = (code_i == W'(g));
      end
   endgenerate

   p_onehot_r8: assert property (@(posedge clk) disable iff (rst)
      $countones(stb_o) == 1);
endmodule

// File: rtl/mcyc_phclk.sv
module mcyc_phclk
   import mcyc_pkg::*;
#(
   parameter int   W       = CODE_W,
   parameter logic RST_PH2 = 1'b1
)(
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] code_i,
   output logic         ph1_o,
   output logic         ph2_o
);
   logic ph1_d;

   always_comb begin
      ph1_d = (code_i == PH_CAPT) || (code_i == PH_EXEC) ||
              (code_i == WT_CAPT) || (code_i == WT_IDLE);
   end

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         ph1_o <= ~RST_PH2;
         ph2_o <= RST_PH2;
      end else begin
         ph1_o <= ph1_d;
         ph2_o <= ~ph1_d;
      end
   end

   p_ph_compl_r6: assert property (@(posedge clk) disable iff (rst)
      ph1_o != ph2_o);
   p_ph1_after_capt_r6: assert property (@(posedge clk) disable iff (rst)
      (code_i == PH_CAPT) |=> ph1_o);
   p_ph2_after_wdrive_r6: assert property (@(posedge clk) disable iff (rst)
      (code_i == WT_DRIVE) |=> ph2_o);
endmodule

// File: rtl/mcyc_seq.sv
module mcyc_seq
   import mcyc_pkg::*;
#(
   parameter int W = CODE_W,
   localparam int N = 1 << W
)(
   input  logic         clk,
   input  logic         rst,
   input  logic         ready_i,
   output logic [W-1:0] code_o,
   output logic [N-1:0] stb_o,
   output logic         done_o,
   output logic         capture_o,
   output logic         ph1_o,
   output logic         ph2_o
);
   mcyc_step #(.W(W)) u_step (
      .clk(clk), .rst(rst), .ready_i(ready_i), .code_o(code_o)
   );

   mcyc_strobe #(.W(W)) u_strobe (
      .clk(clk), .rst(rst), .code_i(code_o), .stb_o(stb_o)
   );

   mcyc_phclk #(.W(W), .RST_PH2(1'b1)) u_phclk (
      .clk(clk), .rst(rst), .code_i(code_o), .ph1_o(ph1_o), .ph2_o(ph2_o)
   );

   assign done_o    = stb_o[PH_EXEC];
   assign capture_o = (stb_o[PH_CAPT] | stb_o[WT_CAPT]) & ready_i;

   p_done_then_addr_r9: assert property (@(posedge clk) disable iff (rst)
      done_o |=> (code_o == PH_ADDR));
   p_capt_exit_r10: assert property (@(posedge clk) disable iff (rst)
      capture_o |=> (code_o == PH_EXEC));
endmodule

// File: tb/mcyc_seq_tb.sv
module mcyc_seq_tb;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       ready_i = 1'b1;
   logic [2:0] code_o;
   logic [7:0] stb_o;
   logic       done_o, capture_o, ph1_o, ph2_o;

   int total = 0;
   int bad = 0;

   always #4 clk = ~clk;

   mcyc_seq u_dut (
      .clk(clk), .rst(rst), .ready_i(ready_i), .code_o(code_o), .stb_o(stb_o),
      .done_o(done_o), .capture_o(capture_o), .ph1_o(ph1_o), .ph2_o(ph2_o)
   );

   int   exp_code = 6;
   logic exp_ph1 = 1'b0;
   int   cyc_len = 0;
   int   waits = 0;
   logic last_ph2 = 1'b1;
   int   run_len = 0;
   int   flips = 0;
   logic [15:0] lfsr = 16'hACE1;
   logic was_exec;

   task automatic chk(input bit ok, input string tag, input int act, input int expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
      end
   endtask

   function automatic int nxt(input int c, input logic r);
      case (c)
         6: return 7;
         7: return 5;
         5: return r ? 4 : 0;
         4: return 6;
         0: return 2;
         2: return 3;
         3: return 1;
         1: return r ? 4 : 0;
         default: return 6;
      endcase
   endfunction

   // called just after a falling edge
   task automatic step(input logic r);
      bit samp;
      ready_i = r;
      #1;
      samp = (exp_code == 5) || (exp_code == 1);
      chk(code_o == 3'(exp_code), "R2 R3 R4 R11 code", code_o, exp_code);
      chk(stb_o == (8'd1 << exp_code), "R8 strobe", stb_o, 1 << exp_code);
      chk(done_o == (exp_code == 4), "R9 done", done_o, exp_code == 4);
      chk(capture_o == (samp && r), "R10 capture", capture_o, samp && r);
      chk(ph1_o == exp_ph1 && ph2_o == !exp_ph1, "R6 phase clocks", ph1_o, exp_ph1);
      if (ph2_o == last_ph2) run_len++;
      else begin
         if (flips >= 1) chk(run_len == 2, "R7 run length", run_len, 2);
         flips++;
         run_len = 1;
         last_ph2 = ph2_o;
      end
      cyc_len++;
      if (samp && !r) waits++;
      was_exec = (exp_code == 4);
      if (was_exec) begin
         chk(cyc_len == 4 + 4 * waits, "R5 cycle length", cyc_len, 4 + 4 * waits);
         cyc_len = 0;
         waits = 0;
      end
      exp_ph1 = (exp_code == 5) || (exp_code == 4) || (exp_code == 1) || (exp_code == 0);
      exp_code = nxt(exp_code, r);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      @(negedge clk);
   endtask

   // memory cycles with nw waits each; junk Ready outside sampling phases (R11)
   task automatic run_cycles(input int nw, input int ncyc);
      for (int k = 0; k < ncyc; k++) begin
         int rem = nw;
         was_exec = 1'b0;
         while (!was_exec) begin
            logic r;
            if (exp_code == 5 || exp_code == 1) begin
               r = (rem == 0);
               if (!r) rem--;
            end else r = lfsr[0];
            step(r);
         end
      end
   endtask

   initial begin
      repeat (2) @(negedge clk);
      // R1: reset state
      chk(code_o == 3'd6, "R1 reset code", code_o, 6);
      chk(ph1_o == 1'b0, "R1 reset ph1", ph1_o, 0);
      chk(ph2_o == 1'b1, "R1 reset ph2", ph2_o, 1);
      chk(done_o == 1'b0, "R1 reset done", done_o, 0);
      rst = 1'b0;
      for (int nw = 0; nw <= 6; nw++) run_cycles(nw, 3);
      for (int i = 0; i < 300; i++) step(lfsr[3]);
      for (int i = 0; i < 64; i++) step(1'(i % 2));
      run_cycles(0, 2);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(8 * 200000);
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule